// File: doc/BRIEF.md
# Gated Signature Analysis Register

This block compresses a serial bit stream into a 16-bit signature for a logic-probe style fault finder. Four probe lines arrive from another clock domain: a probe clock, a start line, a stop line and a data line. Two-flop synchronisers bring all four into the system clock domain. The block then looks for the active edge of the probe clock. Each of the three control lines has its own polarity select. Start and stop are only looked at on active probe-clock edges, and they act on transitions rather than on levels.

A start transition opens a measurement window. While the window is open, each active probe-clock edge shifts one data bit into a right-shifting feedback register. A stop transition closes the window. On that edge the register value is published as the signature, a one-cycle valid strobe is raised, and the register returns to zero for the next window. The signature is also offered as four 5-bit symbol codes that a display driver can turn into glyphs. The probe clock must toggle slower than half the system clock rate.

Top module: `gated_sig_analyzer`

## Requirements
- R1: A probe-clock edge is active when it matches `clk_rising` (1 = rising edge, 0 = falling edge). Only active edges advance the block, and each active edge is acted on once.
- R2: When the window is closed, a start event on an active edge opens it. `gate_open` goes high, and the data bit present on that same edge is the first bit shifted in.
- R3: When the window is open, a stop event on an active edge closes it. The data bit present on the closing edge is not shifted in.
- R4: For each shifted bit, the feedback bit is data XOR state bits 0, 4, 7 and 9. The state moves one place toward bit 0, and the feedback bit enters at bit 15.
- R5: When the window closes, `sig_value` takes the state value and `sig_valid` is high for exactly one system cycle. The state is then zero, so the next window starts from zero. `sig_value` holds its value between closes.
- R6: `sym_codes[5k+4:5k]` holds the bit-reversed nibble k of `sig_value` (nibble 0 = bits 3:0), with bit 4 zero. The code indexes the glyph list 0,1,2,3,4,5,6,7,8,9,A,C,F,H,P,U.
- R7: An event is a change, from the value seen at the previous active edge, to the active level: high when `start_falling`/`stop_falling` is 0, low when it is 1. A stop event while closed and a start event while open have no effect.
- R8: If start and stop events occur on the same active edge while the window is closed, the window opens and the bit on that edge is shifted in.
- R9: After reset, the stored previous start and stop values are the inactive levels. A line that is already at its active level therefore counts as an event on the first active edge.
- R10: Synchronous active-high reset closes the window, clears the state and `sig_value`, and holds `sig_valid` low.
- R11: While the window is closed, data bits on active edges do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_clk | input | 1 | Asynchronous probe clock |
| start_in | input | 1 | Asynchronous start line |
| stop_in | input | 1 | Asynchronous stop line |
| data_in | input | 1 | Asynchronous data line |
| start_falling | input | 1 | Start active level is low when 1 |
| stop_falling | input | 1 | Stop active level is low when 1 |
| clk_rising | input | 1 | Rising probe-clock edge is active when 1 |
| gate_open | output | 1 | Measurement window is open |
| sig_valid | output | 1 | One-cycle strobe when a signature is published |
| sig_value | output | 16 | Last published signature |
| sym_codes | output | 20 | Four 5-bit glyph indices, nibble 0 in the low field |

## Verification
The bench compares signatures for a set of bit patterns against a bench-side model of the feedback polynomial. Each window is preceded by idle edges with data high. A design that shifted while closed, or that kept state from the previous window, would give a different signature. The bench sets data high on the closing edge, so a design that shifted one bit too many would fail. It also checks that simultaneous start and stop opens the window, that retriggering start mid-window does not restart it, and that a stop while closed does nothing. The inverted start/stop polarities, the rising probe-clock mode, and a start line held active through reset are each run as well. A wrong edge detector would count both edges or miss the first one.

// File: rtl/sigan_pkg.sv
package sigan_pkg;

    localparam int SIG_W     = 16;
    localparam int NIBBLES   = SIG_W / 4;
    localparam int SYM_W     = 5;
    localparam int CODES_W   = NIBBLES * SYM_W;
    localparam logic [SIG_W-1:0] TAP_MASK = 16'h0291;

    typedef logic [SYM_W-1:0] sym_code_t;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

    typedef struct packed {
        logic pclk;
        logic start;
        logic stop;
        logic data;
    } probe_lines_t;

    // Glyph index is the nibble read with its bit order reversed.
    function automatic sym_code_t nibble_to_code(input logic [3:0] nib);
        return {1'b0, nib[0], nib[1], nib[2], nib[3]};
    endfunction

    function automatic logic next_feedback(input logic [SIG_W-1:0] st, input logic din);
        return din ^ (^(st & TAP_MASK));
    endfunction

endpackage

// File: rtl/sigan_sync.sv
module sigan_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) chain[s] <= chain[s-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sigan_edge_detect.sv
module sigan_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_s,
    input  logic rise_sel,
    output logic strobe
);
    logic last_level;

    always_ff @(posedge clk) begin
        last_level <= level_s;
    end

    always_comb begin
        strobe = !rst && (level_s != last_level) && (level_s == rise_sel);
    end

    p_strobe_isolated_r1: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/sigan_gate_ctrl.sv
module sigan_gate_ctrl import sigan_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       start_s,
    input  logic       stop_s,
    input  logic       start_falling,
    input  logic       stop_falling,
    output logic       shift_en,
    output logic       close_evt,
    output win_state_t state
);
    logic prev_start, prev_stop;
    logic start_evt, stop_evt, open_now;

    always_comb begin
        start_evt = (start_s != prev_start) && (start_s == !start_falling);
        stop_evt  = (stop_s  != prev_stop)  && (stop_s  == !stop_falling);
        // Start is examined first; stop only matters once the window is open.
        open_now  = strobe && (state == WIN_CLOSED) && start_evt;
        close_evt = strobe && (state == WIN_OPEN) && stop_evt;
        shift_en  = open_now || (strobe && (state == WIN_OPEN) && !stop_evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WIN_CLOSED;
            prev_start <= start_falling;
            prev_stop  <= stop_falling;
        end else if (strobe) begin
            prev_start <= start_s;
            prev_stop  <= stop_s;
            if (open_now)       state <= WIN_OPEN;
            else if (close_evt) state <= WIN_CLOSED;
        end
    end

    p_window_moves_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> $past(strobe));
endmodule

// File: rtl/sigan_shift_reg.sv
module sigan_shift_reg import sigan_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             clear,
    input  logic             din,
    output logic [SIG_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst || clear)  state <= '0;
        else if (shift_en) state <= {next_feedback(state, din), state[SIG_W-1:1]};
    end
endmodule

// File: rtl/sigan_symbol_map.sv
module sigan_symbol_map import sigan_pkg::*; (
    input  logic [SIG_W-1:0]   sig,
    output logic [CODES_W-1:0] codes
);
    for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
        assign codes[k*SYM_W +: SYM_W] = nibble_to_code(sig[k*4 +: 4]);
    end
endmodule

// File: rtl/gated_sig_analyzer.sv
module gated_sig_analyzer import sigan_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               probe_clk,
    input  logic               start_in,
    input  logic               stop_in,
    input  logic               data_in,
    input  logic               start_falling,
    input  logic               stop_falling,
    input  logic               clk_rising,
    output logic               gate_open,
    output logic               sig_valid,
    output logic [SIG_W-1:0]   sig_value,
    output logic [CODES_W-1:0] sym_codes
);
    probe_lines_t     raw, synced;
    logic             strobe, shift_en, close_evt;
    win_state_t       win;
    logic [SIG_W-1:0] sr_state;

    assign raw = '{pclk: probe_clk, start: start_in, stop: stop_in, data: data_in};

    sigan_sync #(.WIDTH($bits(probe_lines_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw),
        .q   (synced)
    );

    sigan_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_s  (synced.pclk),
        .rise_sel (clk_rising),
        .strobe   (strobe)
    );

    sigan_gate_ctrl u_gate (
        .clk           (clk),
        .rst           (rst),
        .strobe        (strobe),
        .start_s       (synced.start),
        .stop_s        (synced.stop),
        .start_falling (start_falling),
        .stop_falling  (stop_falling),
        .shift_en      (shift_en),
        .close_evt     (close_evt),
        .state         (win)
    );

    sigan_shift_reg u_sr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .clear    (close_evt),
        .din      (synced.data),
        .state    (sr_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_value <= '0;
            sig_valid <= 1'b0;
        end else begin
            sig_valid <= close_evt;
            if (close_evt) sig_value <= sr_state;
        end
    end

    sigan_symbol_map u_map (
        .sig   (sig_value),
        .codes (sym_codes)
    );

    assign gate_open = (win == WIN_OPEN);

    p_open_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_open) |-> $past(strobe));
    p_closed_at_publish_r3: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> !gate_open);
    p_cleared_at_publish_r5: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> (sr_state == '0));
    p_sig_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !sig_valid |-> $stable(sig_value));
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        sig_valid |=> !sig_valid);
    p_hold_while_closed_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(gate_open) && !gate_open) |-> $stable(sr_state));
endmodule

// File: tb/test_gated_sig_analyzer.sv
module test_gated_sig_analyzer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        probe_clk = 1'b1;
    logic        start_in = 1'b0, stop_in = 1'b0, data_in = 1'b0;
    logic        start_falling = 1'b0, stop_falling = 1'b0, clk_rising = 1'b0;
    logic        gate_open, sig_valid;
    logic [15:0] sig_value;
    logic [19:0] sym_codes;

    int          n_checks = 0;
    int          n_fail = 0;
    int          vcount = 0;
    logic [15:0] cap_sig = '0;
    logic [19:0] cap_codes = '0;

    always #2 clk = ~clk;

    gated_sig_analyzer i_gated_sig_analyzer (
        .clk(clk), .rst(rst), .probe_clk(probe_clk), .start_in(start_in),
        .stop_in(stop_in), .data_in(data_in), .start_falling(start_falling),
        .stop_falling(stop_falling), .clk_rising(clk_rising),
        .gate_open(gate_open), .sig_valid(sig_valid), .sig_value(sig_value),
        .sym_codes(sym_codes)
    );

    always @(negedge clk) begin
        if (!rst && sig_valid) begin
            vcount++;
            cap_sig   = sig_value;
            cap_codes = sym_codes;
        end
    end

    // stimulus: bit count in the top six bits, bits in the low 32, first bit in bit 0
    localparam logic [37:0] VECS [6] = '{
        {6'd8,  32'h0000_0000},
        {6'd1,  32'h0000_0001},
        {6'd16, 32'h0000_FFFF},
        {6'd32, 32'hDEAD_BEEF},
        {6'd20, 32'h000A_5A5A},
        {6'd3,  32'h0000_0005}
    };

    function automatic logic [15:0] model(input logic [31:0] bits, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = bits[i] ^ r[0] ^ r[4] ^ r[7] ^ r[9];
            r = {fb, r[15:1]};
        end
        return r;
    endfunction

    function automatic logic [19:0] codes_of(input logic [15:0] s);
        logic [19:0] c;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] nb;
            nb = s[4*k +: 4];
            c[5*k +: 5] = {1'b0, nb[0], nb[1], nb[2], nb[3]};
        end
        return c;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pedge(input logic st, input logic sp, input logic d);
        @(negedge clk);
        start_in = st ^ start_falling;
        stop_in  = sp ^ stop_falling;
        data_in  = d;
        repeat (4) @(negedge clk);
        probe_clk = clk_rising;
        repeat (5) @(negedge clk);
        probe_clk = ~clk_rising;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        probe_clk = ~clk_rising;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_window(input logic [31:0] bits, input int n, input logic close_d, input string req);
        int v0;
        logic [15:0] exp;
        pedge(1'b0, 1'b0, 1'b1);
        pedge(1'b0, 1'b0, 1'b1);
        v0 = vcount;
        for (int i = 0; i < n; i++) pedge(1'b1, 1'b0, bits[i]);
        pedge(1'b1, 1'b1, close_d);
        pedge(1'b0, 1'b0, 1'b0);
        exp = model(bits, n);
        check(vcount == v0 + 1, {req, " R5 one valid pulse"}, vcount - v0, 1);
        check(cap_sig == exp, {req, " R4 signature"}, cap_sig, exp);
        check(cap_codes == codes_of(exp), {req, " R6 symbol codes"}, cap_codes, codes_of(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v0;
        do_reset();
        // R10 reset state
        check(gate_open == 1'b0, "R10 gate closed", gate_open, 0);
        check(sig_valid == 1'b0, "R10 valid low", sig_valid, 0);
        check(sig_value == 16'h0, "R10 sig cleared", sig_value, 0);

        // table walk; consecutive windows also show the clear of R5 and R11 idle data
        for (int v = 0; v < 6; v++)
            run_window(VECS[v][31:0], int'(VECS[v][37:32]), v[0], "R1 R3 table");

        // hand values: zeros give 0000, single one gives 0x8000 / code 1 in nibble 3
        run_window(32'h0, 8, 1'b1, "R11 zeros");
        check(cap_sig == 16'h0000, "R11 no shift while closed", cap_sig, 16'h0000);
        run_window(32'h1, 1, 1'b1, "R3 one bit");
        check(cap_sig == 16'h8000, "R3 closing bit not shifted", cap_sig, 16'h8000);
        check(cap_codes == 20'h08000, "R6 glyph index one", cap_codes, 20'h08000);

        // R7: stop while closed does nothing
        v0 = vcount;
        pedge(1'b0, 1'b0, 1'b1);
        pedge(1'b0, 1'b1, 1'b1);
        pedge(1'b0, 1'b0, 1'b1);
        check(vcount == v0, "R7 stop while closed ignored", vcount - v0, 0);
        check(gate_open == 1'b0, "R7 gate stays closed", gate_open, 0);

        // R2 / R7: start retrigger while open does not restart
        pedge(1'b1, 1'b0, 1'b1);
        check(gate_open == 1'b1, "R2 gate opens", gate_open, 1);
        pedge(1'b0, 1'b0, 1'b1);
        pedge(1'b1, 1'b0, 1'b0);
        pedge(1'b1, 1'b1, 1'b1);
        pedge(1'b0, 1'b0, 1'b0);
        check(cap_sig == model(32'b011, 3), "R7 start while open ignored", cap_sig, model(32'b011, 3));

        // R8: start and stop on the same edge while closed
        pedge(1'b0, 1'b0, 1'b0);
        pedge(1'b1, 1'b1, 1'b1);
        check(gate_open == 1'b1, "R8 start wins", gate_open, 1);
        pedge(1'b1, 1'b1, 1'b0);
        pedge(1'b1, 1'b0, 1'b1);
        pedge(1'b1, 1'b1, 1'b0);
        pedge(1'b0, 1'b0, 1'b0);
        check(cap_sig == model(32'b101, 3), "R8 signature", cap_sig, model(32'b101, 3));

        // R9: start already active across reset counts on first edge
        start_in = 1'b1;
        do_reset();
        pedge(1'b1, 1'b0, 1'b1);
        check(gate_open == 1'b1, "R9 held start opens", gate_open, 1);
        pedge(1'b1, 1'b1, 1'b0);
        check(cap_sig == 16'h8000, "R9 signature", cap_sig, 16'h8000);
        pedge(1'b0, 1'b0, 1'b0);

        // R7 inverted start/stop levels
        start_falling = 1'b1;
        stop_falling  = 1'b1;
        start_in = 1'b1;
        stop_in  = 1'b1;
        do_reset();
        check(gate_open == 1'b0, "R9 falling idle closed", gate_open, 0);
        run_window(32'h0000_C3A5, 16, 1'b1, "R7 falling levels");

        // R1 rising probe clock
        start_falling = 1'b0;
        stop_falling  = 1'b0;
        clk_rising    = 1'b1;
        start_in = 1'b0;
        stop_in  = 1'b0;
        do_reset();
        run_window(32'h0123_4567, 24, 1'b0, "R1 rising edge");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule